// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block sits at the end of a full/low-speed host controller's transaction path. Each time a transaction for one transfer descriptor finishes, the schedule walker presents the descriptor's 32-bit control/status word, the PID and maximum-length field from its token, and the outcome of the bus transaction. The outcome is either a received or sent byte count, or one of four failures: stall, babble, NAK or a generic error such as a timeout or CRC failure. One clock later the block returns four things: the control word to write back to memory, a two-bit interrupt request mask for the end of the frame, a USB-error flag for the host status register, and a result class. The result class tells the walker to count the descriptor as complete, to move on to the next queue, or to abandon the rest of the frame.

The block also emits a one-cycle flush pulse whenever the outcome counts as a failure. The walker uses it to discard any work it has already pipelined for the same endpoint. Lengths in the control word and in the token use minus-one encoding, so the 11-bit field value all-ones stands for zero bytes. The block handles the wrap in both directions. The retry counter is two bits wide, and a starting value of zero means unlimited retries.

Top module: `td_status_update`

## Requirements
- R1: `out_vld` rises exactly one clock after `in_vld` is sampled high. While `out_vld` is low, `out_irq`, `out_usb_err`, `out_result` and `out_flush` are zero. After reset all outputs, including `out_ctrl`, are zero.
- R2: If the active bit (control bit 23) is clear on input, `out_ctrl` equals `in_ctrl`, the result is next-queue (code 1), and the irq, error and flush outputs stay zero, whatever the outcome.
- R3: Outcome data (`in_kind` 0) on an active descriptor writes (length − 1) mod 2048 into control bits 10:0, clears active (bit 23) and NAK (bit 19), and gives result complete (code 0). If interrupt-on-complete (bit 24) is set, `out_irq[0]` is set. A zero-byte transfer records 0x7FF.
- R4: The maximum length is (`in_maxfld` + 1) mod 2048. For PID IN (0x69), a byte count above the maximum is babble. The length field is still written, babble (bit 20) and stalled (bit 22) are set, active is cleared, `out_usb_err` is set, `out_irq[0]` follows interrupt-on-complete, the result is stop-frame (code 2), and flush pulses.
- R5: For PID IN, when short-packet detect (bit 29) is set and the count is below the maximum, `out_irq[1]` is set and the result is next-queue. With short-packet detect clear, the same transfer is complete.
- R6: For PIDs other than IN, such as OUT (0xE1) or SETUP (0x2D), a data outcome records the maximum length and ignores `in_count`.
- R7: Stall (`in_kind` 1) sets stalled, clears active, sets `out_usb_err`, applies the interrupt-on-complete rule to `out_irq[0]`, gives result next-queue, leaves the error counter (bits 28:27) unchanged, and pulses flush.
- R8: Babble (`in_kind` 2) sets babble and stalled, clears active, sets `out_usb_err`, applies the interrupt-on-complete rule, gives result stop-frame, and pulses flush.
- R9: NAK (`in_kind` 3) on a non-SETUP PID sets the NAK bit, leaves active, the counter and the timeout bit (bit 18) unchanged, raises no USB error, gives result next-queue, and pulses flush.
- R10: Error (`in_kind` 4 and any undefined code) sets timeout and gives result next-queue. A nonzero counter is decremented. On reaching zero, active is cleared, `out_usb_err` is set and the interrupt-on-complete rule applies. A counter that starts at zero stays zero and leaves active set.
- R11: NAK on a SETUP PID sets the NAK bit and then takes the full error path of R10.
- R12: When isochronous (bit 25) is set on an active descriptor, active is cleared for every outcome.
- R13: `out_flush` pulses for stall, babble, NAK, error and IN oversize. It stays low for successful, short and inactive descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Update request strobe |
| in_ctrl | input | 32 | Descriptor control/status word as read |
| in_pid | input | 8 | Token PID |
| in_maxfld | input | 11 | Token maximum-length field (minus-one encoded) |
| in_kind | input | 3 | Outcome: 0 data, 1 stall, 2 babble, 3 NAK, 4+ error |
| in_count | input | 12 | Bytes transferred for a data outcome |
| out_vld | output | 1 | Result valid, one clock after request |
| out_ctrl | output | 32 | Updated control/status word |
| out_irq | output | 2 | Bit 0 completion interrupt, bit 1 short-packet interrupt |
| out_usb_err | output | 1 | USB error flag for host status |
| out_result | output | 2 | 0 complete, 1 next queue, 2 stop frame |
| out_flush | output | 1 | Discard pipelined work for this endpoint |

## Verification
IN data is driven with counts equal to, below and above the maximum, and with a maximum-length field of all-ones. These cases separate complete, short-packet and babble, and they expose an off-by-one in either minus-one encoding. OUT and SETUP data use a count that differs from the maximum, which shows whether the count is wrongly recorded. Error outcomes start the counter at three, one and zero, which separates plain decrement, exhaustion and unlimited retry. NAK is sent on IN, on SETUP and on an isochronous descriptor, which shows the plain retry, the fall-through to the error path and the forced clearing of active.

// File: rtl/td_status_update.sv
module td_status_update #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [31:0]      in_ctrl,
  input  logic [7:0]       in_pid,
  input  logic [LEN_W-1:0] in_maxfld,
  input  logic [2:0]       in_kind,
  input  logic [LEN_W:0]   in_count,
  output logic             out_vld,
  output logic [31:0]      out_ctrl,
  output logic [1:0]       out_irq,
  output logic             out_usb_err,
  output logic [1:0]       out_result,
  output logic             out_flush
);
  localparam int CNT_W = LEN_W + 1;
  localparam int B_SPD = 29, B_CNT = 27, B_ISO = 25, B_IOC = 24, B_ACT = 23;
  localparam int B_STL = 22, B_BAB = 20, B_NAK = 19, B_TMO = 18;
  localparam logic [7:0] PID_IN = 8'h69, PID_SETUP = 8'h2D;
  localparam logic [2:0] K_DATA = 3'd0, K_STALL = 3'd1, K_BABBLE = 3'd2, K_NAK = 3'd3;
  localparam logic [1:0] RES_DONE = 2'd0, RES_NEXT = 2'd1, RES_STOP = 2'd2;

  logic [LEN_W-1:0] max_len;
  logic [CNT_W-1:0] rx_len;
  logic             is_in, is_setup;
  logic [31:0]      n_ctrl;
  logic [1:0]       n_irq, n_res, cnt;
  logic             n_err, n_flush, err_path;

  assign max_len  = in_maxfld + LEN_W'(1);
  assign is_in    = in_pid == PID_IN;
  assign is_setup = in_pid == PID_SETUP;
  assign rx_len   = is_in ? in_count : {1'b0, max_len};
  assign cnt      = in_ctrl[B_CNT+1:B_CNT];

  always_comb begin
    n_ctrl   = in_ctrl;
    n_irq    = '0;
    n_err    = 1'b0;
    n_res    = RES_NEXT;
    n_flush  = 1'b0;
    err_path = 1'b0;
    if (in_ctrl[B_ACT]) begin
      if (in_ctrl[B_ISO]) n_ctrl[B_ACT] = 1'b0;
      case (in_kind)
        K_DATA: begin
          n_ctrl[LEN_W-1:0] = rx_len[LEN_W-1:0] - LEN_W'(1);
          n_ctrl[B_ACT] = 1'b0;
          n_ctrl[B_NAK] = 1'b0;
          n_irq[0] = in_ctrl[B_IOC];
          n_res = RES_DONE;
          if (is_in && in_count > CNT_W'(max_len)) begin
            n_ctrl[B_BAB] = 1'b1;
            n_ctrl[B_STL] = 1'b1;
            n_err   = 1'b1;
            n_res   = RES_STOP;
            n_flush = 1'b1;
          end else if (is_in && in_ctrl[B_SPD] && in_count < CNT_W'(max_len)) begin
            n_irq[1] = 1'b1;
            n_res    = RES_NEXT;
          end
        end
        K_STALL: begin
          n_ctrl[B_STL] = 1'b1;
          n_ctrl[B_ACT] = 1'b0;
          n_err    = 1'b1;
          n_irq[0] = in_ctrl[B_IOC];
          n_flush  = 1'b1;
        end
        K_BABBLE: begin
          n_ctrl[B_BAB] = 1'b1;
          n_ctrl[B_STL] = 1'b1;
          n_ctrl[B_ACT] = 1'b0;
          n_err    = 1'b1;
          n_irq[0] = in_ctrl[B_IOC];
          n_res    = RES_STOP;
          n_flush  = 1'b1;
        end
        K_NAK: begin
          n_ctrl[B_NAK] = 1'b1;
          n_flush  = 1'b1;
          err_path = is_setup;
        end
        default: begin
          n_flush  = 1'b1;
          err_path = 1'b1;
        end
      endcase
      if (err_path) begin
        n_ctrl[B_TMO] = 1'b1;
        if (cnt != 2'd0) begin
          n_ctrl[B_CNT+1:B_CNT] = cnt - 2'd1;
          if (cnt == 2'd1) begin
            n_ctrl[B_ACT] = 1'b0;
            n_err    = 1'b1;
            n_irq[0] = in_ctrl[B_IOC];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld     <= 1'b0;
      out_ctrl    <= '0;
      out_irq     <= '0;
      out_usb_err <= 1'b0;
      out_result  <= '0;
      out_flush   <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_ctrl    <= n_ctrl;
        out_irq     <= n_irq;
        out_usb_err <= n_err;
        out_result  <= n_res;
        out_flush   <= n_flush;
      end else begin
        out_irq     <= '0;
        out_usb_err <= 1'b0;
        out_result  <= '0;
        out_flush   <= 1'b0;
      end
    end
  end
endmodule

module td_status_update_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [31:0] in_ctrl,
  input logic [2:0]  in_kind,
  input logic        out_vld,
  input logic [31:0] out_ctrl,
  input logic [1:0]  out_irq,
  input logic        out_usb_err,
  input logic [1:0]  out_result,
  input logic        out_flush
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_irq == 2'b00 && !out_usb_err && !out_flush && out_result == 2'd0));
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_ctrl[23]) |=> (out_ctrl == $past(in_ctrl) && out_result == 2'd1 && !out_flush && !out_usb_err));
  p_short_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_irq[1] |-> out_result == 2'd1);
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_ctrl[23] && in_kind == 3'd1) |=> (out_usb_err && out_ctrl[22] && !out_ctrl[23] && out_result == 2'd1));
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_result == 2'd2) |-> (out_ctrl[22] && out_ctrl[20] && !out_ctrl[23] && out_usb_err));
  p_err_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_usb_err |-> (out_vld && !out_ctrl[23]));
  p_iso_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_ctrl[25]) |=> !out_ctrl[23]);
  p_flush_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_flush |-> (out_vld && out_result != 2'd0));
endmodule

bind td_status_update td_status_update_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ctrl(in_ctrl), .in_kind(in_kind),
  .out_vld(out_vld), .out_ctrl(out_ctrl), .out_irq(out_irq), .out_usb_err(out_usb_err),
  .out_result(out_result), .out_flush(out_flush)
);

// File: tb/td_status_update_bench.sv
module td_status_update_bench;
  localparam logic [31:0] SPD = 32'h1 << 29, ISO = 32'h1 << 25, IOC = 32'h1 << 24;
  localparam logic [31:0] ACT = 32'h1 << 23, STL = 32'h1 << 22, BAB = 32'h1 << 20;
  localparam logic [31:0] NAK = 32'h1 << 19, TMO = 32'h1 << 18;
  localparam logic [31:0] C1 = 32'h1 << 27, C2 = 32'h2 << 27, C3 = 32'h3 << 27;
  localparam logic [7:0] P_IN = 8'h69, P_OUT = 8'hE1, P_SETUP = 8'h2D;

  logic clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0;
  logic [31:0] in_ctrl = '0;
  logic [7:0]  in_pid = '0;
  logic [10:0] in_maxfld = '0;
  logic [2:0]  in_kind = '0;
  logic [11:0] in_count = '0;
  logic out_vld, out_usb_err, out_flush;
  logic [31:0] out_ctrl;
  logic [1:0] out_irq, out_result;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  td_status_update u_td_status_update (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ctrl(in_ctrl), .in_pid(in_pid),
    .in_maxfld(in_maxfld), .in_kind(in_kind), .in_count(in_count), .out_vld(out_vld),
    .out_ctrl(out_ctrl), .out_irq(out_irq), .out_usb_err(out_usb_err),
    .out_result(out_result), .out_flush(out_flush)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] c, logic [7:0] p, logic [10:0] mf, logic [2:0] k, logic [11:0] n);
    @(negedge clk);
    in_ctrl = c; in_pid = p; in_maxfld = mf; in_kind = k; in_count = n; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic expect_out(string tag, logic [31:0] c, logic [1:0] irq, logic err, logic [1:0] res, logic fl);
    check({tag, " vld"}, {31'b0, out_vld}, 32'd1);
    check({tag, " ctrl"}, out_ctrl, c);
    check({tag, " irq"}, {30'b0, out_irq}, {30'b0, irq});
    check({tag, " err"}, {31'b0, out_usb_err}, {31'b0, err});
    check({tag, " res"}, {30'b0, out_result}, {30'b0, res});
    check({tag, " flush"}, {31'b0, out_flush}, {31'b0, fl});
  endtask

  task automatic t_reset_latency();
    check("R1 reset vld", {31'b0, out_vld}, 32'd0);
    check("R1 reset ctrl", out_ctrl, 32'd0);
    check("R1 reset flags", {27'b0, out_irq, out_usb_err, out_result}, 32'd0);
    apply(ACT | IOC, P_IN, 11'd7, 3'd1, 12'd0);
    check("R1 one-cycle vld", {31'b0, out_vld}, 32'd1);
    @(negedge clk);
    check("R1 vld drop", {31'b0, out_vld}, 32'd0);
    check("R1 flags quiet", {26'b0, out_irq, out_usb_err, out_result, out_flush}, 32'd0);
  endtask

  task automatic t_inactive();
    apply(C2 | IOC | 32'h123, P_IN, 11'd7, 3'd1, 12'd0);
    expect_out("R2 inactive stall", C2 | IOC | 32'h123, 2'd0, 1'b0, 2'd1, 1'b0);
    apply(ISO | 32'h55, P_SETUP, 11'd7, 3'd4, 12'd0);
    expect_out("R2 inactive error", ISO | 32'h55, 2'd0, 1'b0, 2'd1, 1'b0);
  endtask

  task automatic t_success();
    apply(ACT | IOC | NAK | C3, P_IN, 11'd63, 3'd0, 12'd64);
    expect_out("R3 in full", IOC | C3 | 32'd63, 2'b01, 1'b0, 2'd0, 1'b0);
    apply(ACT, P_IN, 11'h7FF, 3'd0, 12'd0);
    expect_out("R3 zero len", 32'h7FF, 2'b00, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_oversize();
    apply(ACT | IOC, P_IN, 11'd7, 3'd0, 12'd9);
    expect_out("R4 oversize", IOC | BAB | STL | 32'd8, 2'b01, 1'b1, 2'd2, 1'b1);
    apply(ACT, P_IN, 11'h7FF, 3'd0, 12'd1);
    expect_out("R4 zero max", BAB | STL, 2'b00, 1'b1, 2'd2, 1'b1);
  endtask

  task automatic t_short();
    apply(ACT | SPD, P_IN, 11'd63, 3'd0, 12'd10);
    expect_out("R5 short spd", SPD | 32'd9, 2'b10, 1'b0, 2'd1, 1'b0);
    apply(ACT, P_IN, 11'd63, 3'd0, 12'd10);
    expect_out("R5 short nospd", 32'd9, 2'b00, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_out();
    apply(ACT | SPD, P_OUT, 11'd15, 3'd0, 12'd3);
    expect_out("R6 out len", SPD | 32'd15, 2'b00, 1'b0, 2'd0, 1'b0);
    apply(ACT | IOC, P_SETUP, 11'd7, 3'd0, 12'd100);
    expect_out("R6 setup len", IOC | 32'd7, 2'b01, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_stall();
    apply(ACT | IOC | C2, P_IN, 11'd7, 3'd1, 12'd0);
    expect_out("R7 stall", IOC | C2 | STL, 2'b01, 1'b1, 2'd1, 1'b1);
  endtask

  task automatic t_babble();
    apply(ACT, P_OUT, 11'd7, 3'd2, 12'd0);
    expect_out("R8 babble", BAB | STL, 2'b00, 1'b1, 2'd2, 1'b1);
  endtask

  task automatic t_nak();
    apply(ACT | C3, P_IN, 11'd7, 3'd3, 12'd0);
    expect_out("R9 nak in", ACT | C3 | NAK, 2'b00, 1'b0, 2'd1, 1'b1);
  endtask

  task automatic t_error();
    apply(ACT | C3, P_OUT, 11'd7, 3'd4, 12'd0);
    expect_out("R10 err 3to2", ACT | C2 | TMO, 2'b00, 1'b0, 2'd1, 1'b1);
    apply(ACT | IOC | C1, P_IN, 11'd7, 3'd4, 12'd0);
    expect_out("R10 err 1to0", IOC | TMO, 2'b01, 1'b1, 2'd1, 1'b1);
    apply(ACT, P_IN, 11'd7, 3'd7, 12'd0);
    expect_out("R10 err unlimited", ACT | TMO, 2'b00, 1'b0, 2'd1, 1'b1);
  endtask

  task automatic t_setup_nak();
    apply(ACT | C1, P_SETUP, 11'd7, 3'd3, 12'd0);
    expect_out("R11 setup nak", NAK | TMO, 2'b00, 1'b1, 2'd1, 1'b1);
  endtask

  task automatic t_iso();
    apply(ACT | ISO | C3, P_IN, 11'd7, 3'd3, 12'd0);
    expect_out("R12 iso nak", ISO | C3 | NAK, 2'b00, 1'b0, 2'd1, 1'b1);
    apply(ACT | ISO, P_IN, 11'd7, 3'd4, 12'd0);
    expect_out("R12 iso error", ISO | TMO, 2'b00, 1'b0, 2'd1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_latency();
    t_inactive();
    t_success();
    t_oversize();
    t_short();
    t_out();
    t_stall();
    t_babble();
    t_nak();
    t_error();
    t_setup_nak();
    t_iso();
    // R13 flush covered in every expect_out above
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule